// File: doc/BRIEF.md
# Ready-Line Communication Window Controller

This block decides when a host may talk to a sensing device over an I2C-compatible bus that carries an extra open-drain ready line. It sits between the bus decoder, which reports start, repeated start, stop, address match and byte completion as single-cycle strobes, and the sensing engine, which pulses at the end of each conversion. Between conversions it opens a window by pulling the ready line low and holding off the next conversion. The window closes again on a stop, or when the host stays silent for too long; in that case the held data is dropped.

The host may also ask for a window by pulling the ready line low itself. The request passes through a synchroniser and is granted after the conversion in flight. An event-driven policy can be selected that suppresses windows when nothing happened. Slider activity overrides that policy. A watchdog pulses a reset request when the bus carries no valid traffic for its period. The 7-bit address presented to the bus decoder comes from a fixed base plus a two-bit strap.

Top module: `rdy_window_ctrl`

## Requirements
- R1: `dev_addr` equals 0x64 plus `cfg_sub_addr`, so straps 0 to 3 give addresses 0x64 to 0x67.
- R2: Out of reset the ready line is released (`rdy_drive_low` = 0), `conv_hold` is 0 and neither `drop_data` nor `wdt_reset` is high.
- R3: With `cfg_event_mode` = 0, every `conv_done` strobe sets `rdy_drive_low` and `conv_hold` to 1 from the next clock edge.
- R4: With `cfg_event_mode` = 1, a `conv_done` strobe opens a window only if `sense_event`, `slider_touch` or a pending host request is high; otherwise both outputs stay 0.
- R5: With `cfg_event_mode` = 1, `slider_touch` high at `conv_done` opens a window even when `sense_event` is 0.
- R6: A stop strobe during a transfer releases `rdy_drive_low` and `conv_hold` at the next clock edge; a repeated start keeps the window open.
- R7: A window that sees no start for `TIMEOUT_CYC` cycles closes on its own: `rdy_drive_low` is high for exactly `TIMEOUT_CYC` cycles, and `drop_data` pulses for one cycle as it falls. A start inside the window stops this timeout.
- R8: With `cfg_timeout_dis` = 1 an unanswered window stays open indefinitely and `drop_data` stays 0.
- R9: A host pull of the ready line (at least `SYNC_STAGES`+1 cycles low) while sensing is remembered, and the next `conv_done` opens a window in event mode without any event. The request is consumed by that window.
- R10: A host pull made while the controller is driving the ready line low is ignored: after that window closes, an event-mode `conv_done` with no event opens nothing.
- R11: `wdt_reset` pulses for one cycle exactly `WDT_CYC` cycles after the last address match or byte completion, and again every `WDT_CYC` cycles after that. With `cfg_wdt_dis` = 1 it never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_pin_in | input | 1 | Sampled level of the shared ready line |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_addr_match | input | 1 | Own address received strobe |
| ev_byte_done | input | 1 | Byte transferred strobe |
| conv_done | input | 1 | End-of-conversion strobe from the sensing engine |
| sense_event | input | 1 | The finished conversion produced a reportable event |
| slider_touch | input | 1 | An enabled slider or wheel is being touched |
| cfg_sub_addr | input | SUB_W | Address strap added to the base address |
| cfg_event_mode | input | 1 | 1 = open windows only on events, 0 = every conversion |
| cfg_timeout_dis | input | 1 | 1 = unanswered windows never time out |
| cfg_wdt_dis | input | 1 | 1 = watchdog disabled |
| dev_addr | output | ADDR_W | Slave address for the bus decoder |
| rdy_drive_low | output | 1 | Pull the ready line low (window open) |
| conv_hold | output | 1 | Keep the sensing engine from starting a conversion |
| drop_data | output | 1 | One-cycle pulse: window timed out and data is discarded |
| wdt_reset | output | 1 | One-cycle watchdog reset request |

## Verification
Two functions can act in the same cycle: the timeout expiring in a window, and a start strobe arriving in that same cycle. The start must win, so the window moves into the transfer state without a `drop_data` pulse. The bench places a start a few cycles before expiry and checks that the line stays low long past the timeout. The watchdog clear and a watchdog expiry can also coincide. Byte-done strobes are applied at varied offsets and the pulse position is measured against the arithmetic period, so a clear that lost to an expiry would show as an early pulse.

// File: rtl/rdy_window_pkg.sv
package rdy_window_pkg;

   typedef enum logic [1:0] {
      ST_SENSE  = 2'd0,
      ST_WINDOW = 2'd1,
      ST_XFER   = 2'd2
   } win_state_t;

endpackage

// File: rtl/rdy_window_sync.sv
module rdy_window_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] stage_q;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= RESET_VAL;
            else        stage_q[gi] <= d_in;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= RESET_VAL;
            else        stage_q[gi] <= stage_q[gi-1];
         end
      end
   end

   assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/rdy_window_timer.sv
module rdy_window_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expire
);

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign expire = run && !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run || clr || expire)  cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/rdy_window_ctrl.sv
module rdy_window_ctrl
   import rdy_window_pkg::*;
#(
   parameter int          ADDR_W      = 7,
   parameter int          SUB_W       = 2,
   parameter logic [6:0]  BASE_ADDR   = 7'h64,
   parameter int          SYNC_STAGES = 2,
   parameter int          TIMEOUT_CYC = 2_000_000,
   parameter int          WDT_CYC     = 5_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy_pin_in,
   input  logic              ev_start,
   input  logic              ev_rstart,
   input  logic              ev_stop,
   input  logic              ev_addr_match,
   input  logic              ev_byte_done,
   input  logic              conv_done,
   input  logic              sense_event,
   input  logic              slider_touch,
   input  logic [SUB_W-1:0]  cfg_sub_addr,
   input  logic              cfg_event_mode,
   input  logic              cfg_timeout_dis,
   input  logic              cfg_wdt_dis,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              rdy_drive_low,
   output logic              conv_hold,
   output logic              drop_data,
   output logic              wdt_reset
);

   localparam logic [ADDR_W-1:0] BASE_EXT = ADDR_W'(BASE_ADDR);
   localparam bool_aligned_unused = 0;
   localparam bit BASE_ALIGNED = (BASE_EXT[SUB_W-1:0] == '0);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be at least 2");
   end
   if (WDT_CYC < 2) begin : g_bad_wdt
      $error("WDT_CYC must be at least 2");
   end
   if (SUB_W < 1 || SUB_W >= ADDR_W) begin : g_bad_sub
      $error("SUB_W must lie between 1 and ADDR_W-1");
   end

   // address: splice the strap in when the base leaves room, else add
   if (BASE_ALIGNED) begin : g_addr_splice
      assign dev_addr = {BASE_EXT[ADDR_W-1:SUB_W], cfg_sub_addr};
   end else begin : g_addr_add
      assign dev_addr = BASE_EXT + ADDR_W'(cfg_sub_addr);
   end

   win_state_t state_q, state_nxt;
   logic host_level_s;
   logic [SYNC_STAGES-1:0] guard_q;
   logic req_now, pending_q, open_ok, grant;
   logic tmo_expire, wdt_expire;
   logic drop_q, wdt_q;
   logic drive;

   assign drive = (state_q != ST_SENSE);

   rdy_window_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rdy_pin_in),
      .q_out (host_level_s)
   );

   // mask own drive and the synchroniser latency after releasing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) guard_q <= '0;
      else        guard_q <= {guard_q[SYNC_STAGES-2:0], drive};
   end

   assign req_now = !host_level_s && !drive && !(|guard_q);
   assign open_ok = pending_q || req_now || !cfg_event_mode
                    || sense_event || slider_touch;
   assign grant   = (state_q == ST_SENSE) && conv_done && open_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pending_q <= 1'b0;
      else if (grant)  pending_q <= 1'b0;
      else if (req_now) pending_q <= 1'b1;
   end

   rdy_window_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    ((state_q == ST_WINDOW) && !cfg_timeout_dis),
      .clr    (1'b0),
      .expire (tmo_expire)
   );

   rdy_window_timer #(.LIMIT(WDT_CYC)) u_wdt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (!cfg_wdt_dis),
      .clr    (ev_addr_match || ev_byte_done),
      .expire (wdt_expire)
   );

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         ST_SENSE: begin
            if (grant) state_nxt = ST_WINDOW;
         end
         ST_WINDOW: begin
            if (ev_stop)         state_nxt = ST_SENSE;
            else if (ev_start)   state_nxt = ST_XFER;
            else if (tmo_expire) state_nxt = ST_SENSE;
         end
         ST_XFER: begin
            if (ev_stop) state_nxt = ST_SENSE;
         end
         default: state_nxt = ST_SENSE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SENSE;
         drop_q  <= 1'b0;
         wdt_q   <= 1'b0;
      end else begin
         state_q <= state_nxt;
         drop_q  <= (state_q == ST_WINDOW) && !ev_stop && !ev_start && tmo_expire;
         wdt_q   <= wdt_expire;
      end
   end

   assign rdy_drive_low = drive;
   assign conv_hold     = drive;
   assign drop_data     = drop_q;
   assign wdt_reset     = wdt_q;

endmodule

// File: rtl/rdy_window_chk.sv
module rdy_window_chk
   import rdy_window_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input win_state_t st,
   input logic       ev_start,
   input logic       ev_rstart,
   input logic       ev_stop,
   input logic       conv_done,
   input logic       sense_event,
   input logic       slider_touch,
   input logic       pending,
   input logic       req_now,
   input logic       cfg_event_mode,
   input logic       cfg_timeout_dis,
   input logic       cfg_wdt_dis,
   input logic       rdy_drive_low,
   input logic       drop_data,
   input logic       wdt_reset
);

   // R3
   stream_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SENSE && conv_done && !cfg_event_mode) |=> rdy_drive_low);

   // R4
   quiet_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SENSE && conv_done && cfg_event_mode && !sense_event
       && !slider_touch && !pending && !req_now) |=> !rdy_drive_low);

   // R6
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER && ev_stop) |=> !rdy_drive_low);

   // R6
   rstart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER && ev_rstart && !ev_stop) |=> rdy_drive_low);

   // R7
   drop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_data |-> ($past(rdy_drive_low) && !rdy_drive_low));

   // R8
   tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_timeout_dis) |-> !drop_data);

   // R11
   wdt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_wdt_dis) |-> !wdt_reset);

   // R11
   wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset);

endmodule

bind rdy_window_ctrl rdy_window_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .st              (state_q),
   .ev_start        (ev_start),
   .ev_rstart       (ev_rstart),
   .ev_stop         (ev_stop),
   .conv_done       (conv_done),
   .sense_event     (sense_event),
   .slider_touch    (slider_touch),
   .pending         (pending_q),
   .req_now         (req_now),
   .cfg_event_mode  (cfg_event_mode),
   .cfg_timeout_dis (cfg_timeout_dis),
   .cfg_wdt_dis     (cfg_wdt_dis),
   .rdy_drive_low   (rdy_drive_low),
   .drop_data       (drop_data),
   .wdt_reset       (wdt_reset)
);

// File: tb/rdy_window_ctrl_tb.sv
module rdy_window_ctrl_tb;

   localparam int TMO = 40;
   localparam int WDT = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_pull = 1'b0;
   logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr_match = 0, ev_byte_done = 0;
   logic conv_done = 0, sense_event = 0, slider_touch = 0;
   logic [1:0] cfg_sub_addr = 2'd0;
   logic cfg_event_mode = 0, cfg_timeout_dis = 0, cfg_wdt_dis = 0;
   logic [6:0] dev_addr;
   logic rdy_drive_low, conv_hold, drop_data, wdt_reset;
   logic rdy_pin;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   assign rdy_pin = !(rdy_drive_low || host_pull);

   rdy_window_ctrl #(
      .SYNC_STAGES (2),
      .TIMEOUT_CYC (TMO),
      .WDT_CYC     (WDT)
   ) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .rdy_pin_in      (rdy_pin),
      .ev_start        (ev_start),
      .ev_rstart       (ev_rstart),
      .ev_stop         (ev_stop),
      .ev_addr_match   (ev_addr_match),
      .ev_byte_done    (ev_byte_done),
      .conv_done       (conv_done),
      .sense_event     (sense_event),
      .slider_touch    (slider_touch),
      .cfg_sub_addr    (cfg_sub_addr),
      .cfg_event_mode  (cfg_event_mode),
      .cfg_timeout_dis (cfg_timeout_dis),
      .cfg_wdt_dis     (cfg_wdt_dis),
      .dev_addr        (dev_addr),
      .rdy_drive_low   (rdy_drive_low),
      .conv_hold       (conv_hold),
      .drop_data       (drop_data),
      .wdt_reset       (wdt_reset)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_conv(input logic evt, input logic sld);
      conv_done = 1; sense_event = evt; slider_touch = sld;
      @(negedge clk);
      conv_done = 0; sense_event = 0; slider_touch = 0;
   endtask

   task automatic pulse_start;
      ev_start = 1; @(negedge clk); ev_start = 0;
   endtask

   task automatic pulse_stop;
      ev_stop = 1; @(negedge clk); ev_stop = 0;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int len;
      int seen;
      int n;
      tick(3);
      rst_n = 1;
      @(negedge clk);

      // R2 reset state
      check("R2 rdy", rdy_drive_low, 0);
      check("R2 hold", conv_hold, 0);
      check("R2 drop", drop_data, 0);
      check("R2 wdt", wdt_reset, 0);

      // R1 address sweep
      for (int s = 0; s < 4; s++) begin
         cfg_sub_addr = 2'(s);
         #1;
         check("R1 addr", dev_addr, 'h64 + s);
      end

      // R3 R4 R5 policy sweep
      for (int i = 0; i < 8; i++) begin
         logic em, evt, sld, exp_open;
         em = i[0]; evt = i[1]; sld = i[2];
         exp_open = !em || evt || sld;
         cfg_event_mode = em;
         tick(4);
         pulse_conv(evt, sld);
         if (!em)      check("R3 stream open", rdy_drive_low, 1);
         else if (sld) check("R5 slider open", rdy_drive_low, 1);
         else          check("R4 event open", rdy_drive_low, int'(exp_open));
         check("R3 hold", conv_hold, int'(exp_open));
         if (exp_open) begin
            pulse_start();
            pulse_stop();
            check("R6 stop release", rdy_drive_low, 0);
         end
      end

      // R6 repeated start keeps window, stop releases
      cfg_event_mode = 0;
      tick(4);
      pulse_conv(0, 0);
      pulse_start();
      ev_rstart = 1; @(negedge clk); ev_rstart = 0;
      check("R6 rstart keep", rdy_drive_low, 1);
      tick(5);
      check("R6 hold during xfer", conv_hold, 1);
      pulse_stop();
      check("R6 rdy after stop", rdy_drive_low, 0);
      check("R6 hold after stop", conv_hold, 0);

      // R7 timeout length and drop pulse
      tick(4);
      pulse_conv(0, 0);
      len = 0;
      while (rdy_drive_low && len < 200) begin
         len++;
         @(negedge clk);
      end
      check("R7 window length", len, TMO);
      check("R7 drop pulse", drop_data, 1);
      @(negedge clk);
      check("R7 drop one cycle", drop_data, 0);

      // R7 start just before expiry stops the timeout
      tick(4);
      pulse_conv(0, 0);
      tick(TMO - 3);
      pulse_start();
      seen = 0;
      for (int k = 0; k < 2 * TMO; k++) begin
         if (drop_data) seen = 1;
         @(negedge clk);
      end
      check("R7 start holds window", rdy_drive_low, 1);
      check("R7 no drop after start", seen, 0);
      pulse_stop();

      // R8 timeout disabled
      cfg_timeout_dis = 1;
      tick(4);
      pulse_conv(0, 0);
      seen = 0;
      for (int k = 0; k < 3 * TMO; k++) begin
         if (drop_data) seen = 1;
         @(negedge clk);
      end
      check("R8 window stays", rdy_drive_low, 1);
      check("R8 no drop", seen, 0);
      pulse_stop();
      cfg_timeout_dis = 0;

      // R9 host request in event mode
      cfg_event_mode = 1;
      tick(4);
      host_pull = 1; tick(5); host_pull = 0;
      tick(10);
      check("R9 no window before conversion end", rdy_drive_low, 0);
      pulse_conv(0, 0);
      check("R9 request granted", rdy_drive_low, 1);
      pulse_start();
      pulse_stop();
      tick(4);
      pulse_conv(0, 0);
      check("R9 request consumed", rdy_drive_low, 0);

      // R10 host pull during own drive is ignored
      tick(4);
      pulse_conv(1, 0);
      check("R10 window open", rdy_drive_low, 1);
      host_pull = 1; tick(6); host_pull = 0;
      tick(3);
      pulse_start();
      pulse_stop();
      tick(6);
      pulse_conv(0, 0);
      check("R10 pull ignored", rdy_drive_low, 0);

      // R11 watchdog period from several offsets
      for (int off = 0; off < 3; off++) begin
         tick(off * 7 + 1);
         ev_byte_done = 1; @(negedge clk); ev_byte_done = 0;
         n = 0;
         while (n < 2 * WDT + 10) begin
            @(negedge clk);
            n++;
            if (wdt_reset) break;
         end
         check("R11 first pulse", n, WDT);
      end
      n = 0;
      while (n < 2 * WDT + 10) begin
         @(negedge clk);
         n++;
         if (wdt_reset) break;
      end
      check("R11 repeat period", n, WDT);

      // R11 address match also clears
      tick(WDT / 2);
      ev_addr_match = 1; @(negedge clk); ev_addr_match = 0;
      n = 0;
      while (n < 2 * WDT + 10) begin
         @(negedge clk);
         n++;
         if (wdt_reset) break;
      end
      check("R11 addr match clears", n, WDT);

      // R11 disabled
      cfg_wdt_dis = 1;
      seen = 0;
      for (int k = 0; k < 3 * WDT; k++) begin
         @(negedge clk);
         if (wdt_reset) seen = 1;
      end
      check("R11 disabled", seen, 0);
      cfg_wdt_dis = 0;

      finish_run();
   end

endmodule